// File: doc/BRIEF.md
# Dual Byte FIFO with Trigger Thresholds

This block holds the transmit and receive byte queues of a serial bridge. The host writes bytes into the transmit queue and the serializer drains them. The serializer writes received bytes into the receive queue and the host drains them. Both queues are 64 bytes deep. Each queue reports its state all the time: the receive side gives its exact fill count and the transmit side gives its exact free space. Each queue also reports its empty, full and sticky overflow flags. Each queue raises a level-sensitive interrupt request when its programmed threshold is met.

A single 8-bit control write does three things. It enables both queues, it flushes either queue, and it selects one of four trigger thresholds per direction. The transmit and receive encodings are different. Host bursts are back-to-back pushes or pops on consecutive cycles. Read data falls through from the head of the queue, so a popped byte is valid in the same cycle as its pop strobe.

Top module: `uart_fifo_pair`

## Requirements
- R1: Each queue stores 64 bytes in first-in first-out order. The byte at the head is presented combinationally on the read data output, and a pop strobe consumes it at the next clock edge. Pushes and pops may occur on every cycle, including on the same cycle.
- R2: `rx_level_o` equals the number of bytes stored in the receive queue (0 to 64). `tx_space_o` equals 64 minus the number of bytes stored in the transmit queue.
- R3: A push into a full queue is dropped and sets that queue's overflow flag. This also applies when a pop occurs in the same cycle. The flag stays set until that queue is flushed.
- R4: A pop from an empty queue returns 0x00 and leaves the level unchanged.
- R5: Control bit 0 is the enable. While it is 0, pushes and pops are ignored, read data is 0x00, both interrupt requests are low, and stored bytes are kept.
- R6: Control bit 1 flushes the receive queue and control bit 2 flushes the transmit queue. A flush empties the queue and clears its overflow flag at the clock edge after the edge that captured the write. The flush bits are not retained, and the enable and threshold fields take the written values.
- R7: Control bits [5:4] select the transmit threshold: 0 selects 8, 1 selects 16, 2 selects 32 and 3 selects 56. `tx_irq_o` is high while the queues are enabled and the free space is at or above the threshold.
- R8: Control bits [7:6] select the receive threshold: 0 selects 8, 1 selects 16, 2 selects 56 and 3 selects 60. `rx_irq_o` is high while the queues are enabled and the level is at or above the threshold.
- R9: Each queue's empty flag is high when its count is 0. Each queue's full flag is high when its count is 64.
- R10: After reset, both queues are empty, the control register is 0x00 (disabled, both thresholds 8), the overflow flags are clear and both interrupt requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control write data |
| host_tx_push_i | input | 1 | Host push into transmit queue |
| host_tx_data_i | input | 8 | Host transmit byte |
| ser_tx_pop_i | input | 1 | Serializer pop from transmit queue |
| ser_tx_data_o | output | 8 | Transmit queue head byte |
| ser_rx_push_i | input | 1 | Serializer push into receive queue |
| ser_rx_data_i | input | 8 | Received byte |
| host_rx_pop_i | input | 1 | Host pop from receive queue |
| host_rx_data_o | output | 8 | Receive queue head byte |
| rx_level_o | output | 7 | Bytes waiting in receive queue |
| tx_space_o | output | 7 | Free entries in transmit queue |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_full_o | output | 1 | Receive queue full |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_full_o | output | 1 | Transmit queue full |
| rx_ovf_o | output | 1 | Sticky receive overflow |
| tx_ovf_o | output | 1 | Sticky transmit overflow |
| rx_irq_o | output | 1 | Receive threshold request |
| tx_irq_o | output | 1 | Transmit threshold request |

## Verification
The bench fills the receive queue to one below the 60-byte threshold and then exactly to it. A wrong compare would raise the request one byte early or one byte late. It pushes into a full queue with and without a simultaneous pop. A design that accepts either push would corrupt the byte order or report a level of 65. The flush tests check that the threshold fields survive the flush and that a later write without the flush bit leaves the data alone. A flush bit that sticks would keep emptying the queue. Pops from an empty or disabled queue must return zero and must not move the pointers. A design that moves them would return stale bytes later in the random phase.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic [1:0] rx_sel;
    logic [1:0] tx_sel;
    logic       en;
  } ctrl_t;

  function automatic int tx_thr_decode(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return 32;
      default: return 56;
    endcase
  endfunction

  function automatic int rx_thr_decode(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return 56;
      default: return 60;
    endcase
  endfunction
endpackage

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [7:0]    wdata_i,
  output logic          en_o,
  output logic [CW-1:0] tx_thr_o,
  output logic [CW-1:0] rx_thr_o,
  output logic          rx_flush_o,
  output logic          tx_flush_o
);
  ctrl_t ctrl_q;
  logic  rx_flush_q, tx_flush_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      rx_flush_q <= 1'b0;
      tx_flush_q <= 1'b0;
    end else begin
      // flush bits live for one cycle only
      rx_flush_q <= we_i & wdata_i[1];
      tx_flush_q <= we_i & wdata_i[2];
      if (we_i) begin
        ctrl_q.en     <= wdata_i[0];
        ctrl_q.tx_sel <= wdata_i[5:4];
        ctrl_q.rx_sel <= wdata_i[7:6];
      end
    end
  end

  assign en_o       = ctrl_q.en;
  assign tx_thr_o   = CW'(tx_thr_decode(ctrl_q.tx_sel));
  assign rx_thr_o   = CW'(rx_thr_decode(ctrl_q.rx_sel));
  assign rx_flush_o = rx_flush_q;
  assign tx_flush_o = tx_flush_q;

  AST_FLUSH_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_flush_o || tx_flush_o) && !we_i |=> !rx_flush_o && !tx_flush_o); // R6
  AST_TRIG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(tx_thr_o) && $stable(rx_thr_o) && $stable(en_o)); // R7
endmodule

// File: rtl/uart_fifo_buf.sv
module uart_fifo_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          ovf_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          ovf_q;
  logic          do_push, do_pop, drop;

  function automatic logic [AW-1:0] inc_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = en_i && push_i && !full_o;
  assign do_pop  = en_i && pop_i && !empty_o;
  assign drop    = en_i && push_i && full_o;

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (do_push) wr_ptr_q <= inc_ptr(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= inc_ptr(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (drop) ovf_q <= 1'b1;
    end
  end

  // first-word fall-through, zero when nothing readable
  assign rdata_o = (en_i && !empty_o) ? mem_q[rd_ptr_q] : '0;
  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;

  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH)); // R2
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !flush_i |=> ovf_o); // R3
  AST_DROP_KEEPS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && full_o && push_i && !pop_i && !flush_i |=> full_o && ovf_o); // R3
  AST_POP_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && empty_o && !push_i && !flush_i |=> empty_o && rdata_o == '0); // R4
  AST_FLUSH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o && !ovf_o); // R6
endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [7:0]        ctrl_wdata_i,
  input  logic              host_tx_push_i,
  input  logic [DATA_W-1:0] host_tx_data_i,
  input  logic              ser_tx_pop_i,
  output logic [DATA_W-1:0] ser_tx_data_o,
  input  logic              ser_rx_push_i,
  input  logic [DATA_W-1:0] ser_rx_data_i,
  input  logic              host_rx_pop_i,
  output logic [DATA_W-1:0] host_rx_data_o,
  output logic [CW-1:0]     rx_level_o,
  output logic [CW-1:0]     tx_space_o,
  output logic              rx_empty_o,
  output logic              rx_full_o,
  output logic              tx_empty_o,
  output logic              tx_full_o,
  output logic              rx_ovf_o,
  output logic              tx_ovf_o,
  output logic              rx_irq_o,
  output logic              tx_irq_o
);
  logic          en;
  logic [CW-1:0] tx_thr, rx_thr, rx_cnt, tx_cnt;
  logic          rx_flush, tx_flush;

  uart_fifo_ctrl #(.CW(CW)) u_ctrl (
    .clk_i, .rst_ni,
    .we_i      (ctrl_we_i),
    .wdata_i   (ctrl_wdata_i),
    .en_o      (en),
    .tx_thr_o  (tx_thr),
    .rx_thr_o  (rx_thr),
    .rx_flush_o(rx_flush),
    .tx_flush_o(tx_flush)
  );

  uart_fifo_buf #(.DW(DATA_W), .DEPTH(DEPTH)) u_rx (
    .clk_i, .rst_ni,
    .en_i   (en),
    .flush_i(rx_flush),
    .push_i (ser_rx_push_i),
    .wdata_i(ser_rx_data_i),
    .pop_i  (host_rx_pop_i),
    .rdata_o(host_rx_data_o),
    .count_o(rx_cnt),
    .empty_o(rx_empty_o),
    .full_o (rx_full_o),
    .ovf_o  (rx_ovf_o)
  );

  uart_fifo_buf #(.DW(DATA_W), .DEPTH(DEPTH)) u_tx (
    .clk_i, .rst_ni,
    .en_i   (en),
    .flush_i(tx_flush),
    .push_i (host_tx_push_i),
    .wdata_i(host_tx_data_i),
    .pop_i  (ser_tx_pop_i),
    .rdata_o(ser_tx_data_o),
    .count_o(tx_cnt),
    .empty_o(tx_empty_o),
    .full_o (tx_full_o),
    .ovf_o  (tx_ovf_o)
  );

  assign rx_level_o = rx_cnt;
  assign tx_space_o = CW'(DEPTH) - tx_cnt;
  assign rx_irq_o   = en && (rx_cnt >= rx_thr);
  assign tx_irq_o   = en && (tx_space_o >= tx_thr);

  AST_TX_IRQ_WHEN_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && tx_empty_o |-> tx_irq_o); // R7
  AST_RX_IRQ_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && rx_full_o |-> rx_irq_o); // R8
  AST_RX_IRQ_NOT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty_o |-> !rx_irq_o); // R8
  AST_IRQ_OFF_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !rx_irq_o && !tx_irq_o); // R5
endmodule

// File: tb/uart_fifo_pair_tb.sv
`timescale 1ns/1ps
module uart_fifo_pair_tb_top;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = '0;
  logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0] tx_wd = '0, rx_wd = '0;
  logic [7:0] tx_rd, rx_rd;
  logic [6:0] rx_level, tx_space;
  logic       rx_empty, rx_full, tx_empty, tx_full, rx_ovf, tx_ovf, rx_irq, tx_irq;

  always #4 clk = ~clk;

  uart_fifo_pair #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .host_tx_push_i(tx_push), .host_tx_data_i(tx_wd),
    .ser_tx_pop_i(tx_pop), .ser_tx_data_o(tx_rd),
    .ser_rx_push_i(rx_push), .ser_rx_data_i(rx_wd),
    .host_rx_pop_i(rx_pop), .host_rx_data_o(rx_rd),
    .rx_level_o(rx_level), .tx_space_o(tx_space),
    .rx_empty_o(rx_empty), .rx_full_o(rx_full),
    .tx_empty_o(tx_empty), .tx_full_o(tx_full),
    .rx_ovf_o(rx_ovf), .tx_ovf_o(tx_ovf),
    .rx_irq_o(rx_irq), .tx_irq_o(tx_irq)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  logic [7:0] rq[$];
  logic [7:0] tq[$];
  bit m_en = 0, m_rovf = 0, m_tovf = 0;
  int m_rthr = 8, m_tthr = 8;

  function automatic int tx_thr_f(input int s);
    return (s == 0) ? 8 : (s == 1) ? 16 : (s == 2) ? 32 : 56;
  endfunction
  function automatic int rx_thr_f(input int s);
    return (s == 0) ? 8 : (s == 1) ? 16 : (s == 2) ? 56 : 60;
  endfunction

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic check_state();
    chk("R2", "rx_level", rx_level, rq.size());
    chk("R2", "tx_space", tx_space, DEPTH - tq.size());
    chk("R9", "rx_empty", rx_empty, rq.size() == 0);
    chk("R9", "rx_full", rx_full, rq.size() == DEPTH);
    chk("R9", "tx_empty", tx_empty, tq.size() == 0);
    chk("R9", "tx_full", tx_full, tq.size() == DEPTH);
    chk("R3", "rx_ovf", rx_ovf, m_rovf);
    chk("R3", "tx_ovf", tx_ovf, m_tovf);
    chk("R8", "rx_irq", rx_irq, m_en && (rq.size() >= m_rthr));
    chk("R7", "tx_irq", tx_irq, m_en && ((DEPTH - tq.size()) >= m_tthr));
  endtask

  // called right after a negedge; ends right after the next negedge
  task automatic cyc(input bit rp, input bit rpo, input bit tp, input bit tpo,
                     input logic [7:0] rd, input logic [7:0] td);
    int rs, ts;
    rx_push = rp; rx_pop = rpo; rx_wd = rd;
    tx_push = tp; tx_pop = tpo; tx_wd = td;
    #1;
    rs = rq.size(); ts = tq.size();
    if (rpo) chk((m_en && rs > 0) ? "R1" : "R4", "rx_rdata", rx_rd, (m_en && rs > 0) ? rq[0] : 0);
    if (tpo) chk((m_en && ts > 0) ? "R1" : "R4", "tx_rdata", tx_rd, (m_en && ts > 0) ? tq[0] : 0);
    @(posedge clk);
    if (m_en) begin
      if (rp && rs == DEPTH) m_rovf = 1;
      if (tp && ts == DEPTH) m_tovf = 1;
      if (rpo && rs > 0) void'(rq.pop_front());
      if (tpo && ts > 0) void'(tq.pop_front());
      if (rp && rs < DEPTH) rq.push_back(rd);
      if (tp && ts < DEPTH) tq.push_back(td);
    end
    @(negedge clk);
    rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
    check_state();
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_we = 1; ctrl_wdata = v;
    @(posedge clk);
    m_en = v[0]; m_tthr = tx_thr_f(v[5:4]); m_rthr = rx_thr_f(v[7:6]);
    @(negedge clk);
    ctrl_we = 0;
    @(posedge clk);
    if (v[1]) begin rq.delete(); m_rovf = 0; end
    if (v[2]) begin tq.delete(); m_tovf = 0; end
    @(negedge clk);
    check_state();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int s;
    s = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "rx_level", rx_level, 0);
    chk("R10", "tx_space", tx_space, 64);
    chk("R10", "irqs", {rx_irq, tx_irq}, 0);
    chk("R10", "ovf", {rx_ovf, tx_ovf}, 0);
    check_state();

    // R5: disabled pushes are ignored
    cyc(1, 0, 1, 0, 8'h11, 8'h22);
    chk("R5", "rx_level_disabled", rx_level, 0);

    // rx threshold 60, tx threshold 32, enabled
    wr_ctrl(8'hE1);
    for (int i = 0; i < 59; i++) cyc(1, 0, 0, 0, 8'(i + 1), 0);
    chk("R8", "rx_irq_at_59", rx_irq, 0);
    cyc(1, 0, 0, 0, 8'd60, 0);
    chk("R8", "rx_irq_at_60", rx_irq, 1);
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 8'(61 + i), 0);
    chk("R3", "ovf_before", rx_ovf, 0);
    cyc(1, 0, 0, 0, 8'hEE, 0);
    chk("R3", "rx_ovf_set", rx_ovf, 1);
    cyc(1, 1, 0, 0, 8'hEF, 0);  // full: push with pop still dropped
    chk("R3", "level_after_drop", rx_level, 63);
    // tx threshold 32 boundary
    for (int i = 0; i < 32; i++) cyc(0, 0, 1, 0, 0, 8'(8'hA0 + i));
    chk("R7", "tx_irq_space_32", tx_irq, 1);
    cyc(0, 0, 1, 0, 0, 8'hC0);
    chk("R7", "tx_irq_space_31", tx_irq, 0);

    // R5: disable keeps contents, pops read zero
    wr_ctrl(8'hE0);
    cyc(1, 1, 1, 1, 8'h55, 8'h66);
    chk("R5", "rx_kept", rx_level, 63);
    chk("R5", "rx_rdata_disabled", rx_rd, 0);

    // R6: flush rx only, thresholds kept
    wr_ctrl(8'hE3);
    chk("R6", "rx_flushed", rx_level, 0);
    chk("R6", "rx_ovf_cleared", rx_ovf, 0);
    chk("R6", "tx_kept", tx_space, 31);
    wr_ctrl(8'hE1);  // no flush bit: tx untouched
    chk("R6", "tx_no_reflush", tx_space, 31);
    wr_ctrl(8'hE5);
    chk("R6", "tx_flushed", tx_space, 64);

    // R4: pop from empty
    cyc(0, 1, 0, 1, 0, 0);
    chk("R4", "rx_empty_pop_level", rx_level, 0);

    // random phase
    for (int seg = 0; seg < 12; seg++) begin
      int pp;
      logic [7:0] cv;
      cv = 8'($urandom());
      cv[0] = ($urandom_range(0, 5) != 0);
      if ($urandom_range(0, 3) != 0) cv[2:1] = 2'b00;
      wr_ctrl(cv);
      pp = $urandom_range(20, 80);
      for (int k = 0; k < 300; k++) begin
        cyc($urandom_range(0, 99) < pp, $urandom_range(0, 99) >= pp,
            $urandom_range(0, 99) < (100 - pp), $urandom_range(0, 99) >= (100 - pp),
            8'($urandom()), 8'($urandom()));
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule